// File: doc/BRIEF.md
# UART Host Register Block with FIFOs and Interrupts

This block sits between a host bus and the bit-level serial engine of a fast UART. It owns a transmit FIFO and a receive FIFO, 64 entries each, and presents five 32-bit word registers to software: a data port, a fill-level report, an interrupt status word, a control word and a baud divider. Writes to the data port queue bytes for the serial engine. Reads of the data port return the oldest received byte together with tag bits for framing error and break, or an empty marker when nothing is waiting.

Interrupt causes are collected in one status word. Some causes are sticky events cleared by writing one: transmit request, framing error, break and overrun. Others are live conditions: receive level at or above a programmable trigger, and an inactivity timeout. The timeout counts character-time pulses from the serial engine while received data sits unread. One interrupt output is the OR of the causes that the control word enables.

The bus is word addressed. Register reads are combinational from the current state, and a read of the data port pops the receive FIFO on the clock edge that ends the access. The serial engine takes transmit bytes with a valid/ready handshake and delivers received bytes with a single-cycle strobe.

Top module: `uart_host_regs`

## Requirements
- R1: After reset both FIFO levels, the status word, the control word, the rate register and the interrupt output all read zero, and no transmit byte is offered.
- R2: A write to byte offset 0x00 queues bits 7:0 in the 64-entry transmit FIFO. The bytes leave in write order on txb_data while txb_valid and txb_ready are both high. A write while 64 bytes are queued is dropped.
- R3: A read of offset 0x00 pops the receive FIFO and returns the byte in bits 7:0, the framing-error tag in bit 9 and the break tag in bit 10. When the receive FIFO is empty it returns 0x100 (bit 8 set) and pops nothing.
- R4: Offset 0x04 returns the transmit fill level in bits 15:8 and the receive fill level in bits 7:0.
- R5: A byte that arrives while the receive FIFO holds 64 entries is discarded and sets status bit 5 (overrun). The status word is at offset 0x08.
- R6: Status bit 1 is high while the receive level is at least the trigger chosen by control bits 4:2: codes 0 to 5 give 1, 4, 8, 16, 32 and 48 bytes, and codes 6 and 7 give 48. The control word is at offset 0x0C.
- R7: Status bit 0 latches when the transmit level drops from above to at or below the trigger chosen by control bits 1:0 (0, 4, 8 or 16 bytes for codes 0 to 3). Writing one to status bit 6 also sets status bit 0. Status bit 6 itself reads zero.
- R8: Status bit 2 is high when control bits 17:16 are nonzero, the receive FIFO is not empty, and at least 4, 8 or 16 char_tick pulses (codes 1, 2, 3) have arrived since the last push or pop. A push, a pop or an empty FIFO clears it. Code 0 disables it.
- R9: Storing a received byte that has the framing-error tag sets status bit 3. Storing one with the break tag sets status bit 4.
- R10: Writing one to status bits 0, 3, 4 or 5 clears that bit. Writing zero leaves it unchanged.
- R11: irq is high when an enabled cause is pending. Control bit 5 enables bit 0. Control bit 6 enables bits 1 and 2. Control bit 7 enables bits 3, 4 and 5.
- R12: Control reads back bits 17:16 and 7:0 as written, with all other bits zero. The rate register at offset 0x10 keeps bits 7:0, reads them back and drives baud_div.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| txb_valid | output | 1 | Transmit byte available |
| txb_data | output | 8 | Transmit byte |
| txb_ready | input | 1 | Serial engine takes the byte |
| rxb_valid | input | 1 | Received byte strobe |
| rxb_data | input | 8 | Received byte |
| rxb_frame_err | input | 1 | Received byte had a framing error |
| rxb_break | input | 1 | Received byte is a break |
| char_tick | input | 1 | One pulse per character time |
| baud_div | output | 8 | Rate register value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the sticky transmit request, which needs a falling crossing of the transmit trigger, and the overrun, which needs a completely full receive FIFO. The bench holds txb_ready low while it queues a known number of bytes, clears the sticky bit, and then opens txb_ready for an exact number of cycles so the level steps past the trigger one byte at a time. For overrun it strobes 64 bytes into the receive side and then one more, and reads the FIFO back to show the extra byte never entered. The timeout is reached by counting char_tick pulses one at a time against a single waiting byte.

// File: rtl/uart_host_pkg.sv
// Shared definitions for the UART host register block: register word
// indices, the stored control fields and the trigger decode functions.
package uart_host_pkg;

    localparam int REG_DATA  = 0;
    localparam int REG_LEVEL = 1;
    localparam int REG_STAT  = 2;
    localparam int REG_CTRL  = 3;
    localparam int REG_RATE  = 4;

    localparam int ST_TXREQ = 0;
    localparam int ST_RXTRG = 1;
    localparam int ST_RXTMO = 2;
    localparam int ST_FERR  = 3;
    localparam int ST_BRK   = 4;
    localparam int ST_OVR   = 5;
    localparam int ST_SWSET = 6;

    typedef struct packed {
        logic [1:0] tmo_mode;
        logic       err_en;
        logic       rx_en;
        logic       tx_en;
        logic [2:0] rx_trig;
        logic [1:0] tx_trig;
    } ctrl_t;

    // Receive trigger level for a control code.
    function automatic logic [7:0] rx_trig_level(input logic [2:0] code);
        case (code)
            3'd0:    return 8'd1;
            3'd1:    return 8'd4;
            3'd2:    return 8'd8;
            3'd3:    return 8'd16;
            3'd4:    return 8'd32;
            default: return 8'd48;
        endcase
    endfunction

    // Transmit trigger level for a control code.
    function automatic logic [7:0] tx_trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd0;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd16;
        endcase
    endfunction

    // Character times of inactivity for a timeout code.
    function automatic logic [4:0] tmo_limit(input logic [1:0] code);
        case (code)
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/uart_sync_fifo.sv
// Single-clock FIFO with occupancy count.
// Assumes DEPTH is a power of two. Push when full and pop when empty are ignored.
module uart_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_idle_timer.sv
// Counts character-time pulses while received data waits unread.
// Assumes char_tick is a one-cycle pulse. The count saturates at the largest limit.
module uart_rx_idle_timer
    import uart_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       nonempty,
    input  logic       activity,
    input  logic       char_tick,
    output logic       timeout
);
    logic [4:0] idle_cnt;

    // Idle counter: restart on any FIFO activity or when nothing is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!nonempty || activity) begin
            idle_cnt <= '0;
        end else if (char_tick && idle_cnt < 5'd16) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Timeout condition for the selected length.
    always_comb begin
        timeout = (mode != 2'd0) && nonempty && (idle_cnt >= tmo_limit(mode));
    end
endmodule

// File: rtl/uart_irq_status.sv
// Interrupt cause collection: sticky event bits with write-one-to-clear,
// live receive conditions, and the masked interrupt output.
// Assumes a set and a clear of one bit in the same cycle leave it set.
module uart_irq_status
    import uart_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_level,
    input  logic [7:0] rx_level,
    input  ctrl_t      ctrl,
    input  logic       rx_timeout,
    input  logic       ferr_evt,
    input  logic       brk_evt,
    input  logic       ovr_evt,
    input  logic       stat_wr,
    input  logic [6:0] stat_wdata,
    output logic [5:0] stat,
    output logic       irq
);
    logic [7:0] tx_level_d;
    logic       txreq_q, ferr_q, brk_q, ovr_q;
    logic       tx_cross, rx_trg;

    // Falling crossing of the transmit trigger, from last cycle's level.
    always_comb begin
        tx_cross = (tx_level <= tx_trig_level(ctrl.tx_trig)) &&
                   (tx_level_d > tx_trig_level(ctrl.tx_trig));
        rx_trg   = (rx_level >= rx_trig_level(ctrl.rx_trig));
    end

    // Remember the transmit level for crossing detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_level_d <= '0;
        else        tx_level_d <= tx_level;
    end

    // Sticky cause bits: set on event, clear on write of one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txreq_q <= 1'b0;
            ferr_q  <= 1'b0;
            brk_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (tx_cross || (stat_wr && stat_wdata[ST_SWSET]))
                txreq_q <= 1'b1;
            else if (stat_wr && stat_wdata[ST_TXREQ])
                txreq_q <= 1'b0;
            if (ferr_evt)                           ferr_q <= 1'b1;
            else if (stat_wr && stat_wdata[ST_FERR]) ferr_q <= 1'b0;
            if (brk_evt)                            brk_q <= 1'b1;
            else if (stat_wr && stat_wdata[ST_BRK]) brk_q <= 1'b0;
            if (ovr_evt)                            ovr_q <= 1'b1;
            else if (stat_wr && stat_wdata[ST_OVR]) ovr_q <= 1'b0;
        end
    end

    // Status word and masked interrupt.
    always_comb begin
        stat = {ovr_q, brk_q, ferr_q, rx_timeout, rx_trg, txreq_q};
        irq  = (ctrl.tx_en  && txreq_q) ||
               (ctrl.rx_en  && (rx_trg || rx_timeout)) ||
               (ctrl.err_en && (ferr_q || brk_q || ovr_q));
    end
endmodule

// File: rtl/uart_host_regs.sv
// Host register block of a fast UART: transmit and receive FIFOs, level
// report, interrupt status, control and rate registers.
// Assumes a word-aligned byte address. Reads are combinational, and a data
// read pops the receive FIFO at the clock edge that ends the access.
module uart_host_regs
    import uart_host_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 5,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int RXW   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              txb_valid,
    output logic [7:0]        txb_data,
    input  logic              txb_ready,
    input  logic              rxb_valid,
    input  logic [7:0]        rxb_data,
    input  logic              rxb_frame_err,
    input  logic              rxb_break,
    input  logic              char_tick,
    output logic [7:0]        baud_div,
    output logic              irq
);
    logic [ADDR_W-3:0] word_idx;
    logic              wr_data, rd_data, wr_stat, wr_ctrl, wr_rate;
    ctrl_t             ctrl_q;
    logic [7:0]        rate_q;

    logic [LVL_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [RXW-1:0]    rx_head;
    logic              tx_pop, rx_push;
    logic [7:0]        tx_lvl8, rx_lvl8;
    logic              rx_tmo;
    logic [5:0]        stat;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[31:18], bus_wdata[15:10], bus_addr[1:0]};

    // Access decode.
    always_comb begin
        word_idx = bus_addr[ADDR_W-1:2];
        wr_data  = bus_sel &&  bus_wr && (word_idx == (ADDR_W-2)'(REG_DATA));
        rd_data  = bus_sel && !bus_wr && (word_idx == (ADDR_W-2)'(REG_DATA));
        wr_stat  = bus_sel &&  bus_wr && (word_idx == (ADDR_W-2)'(REG_STAT));
        wr_ctrl  = bus_sel &&  bus_wr && (word_idx == (ADDR_W-2)'(REG_CTRL));
        wr_rate  = bus_sel &&  bus_wr && (word_idx == (ADDR_W-2)'(REG_RATE));
    end

    // Control and rate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rate_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= {bus_wdata[17:16], bus_wdata[7:0]};
            if (wr_rate) rate_q <= bus_wdata[7:0];
        end
    end

    assign tx_pop  = txb_ready && !tx_empty;
    assign rx_push = rxb_valid && !rx_full;

    uart_sync_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_data), .wdata(bus_wdata[7:0]),
        .pop(tx_pop), .rdata(txb_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    uart_sync_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rxb_valid), .wdata({rxb_break, rxb_frame_err, rxb_data}),
        .pop(rd_data), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign txb_valid = !tx_empty;
    assign tx_lvl8   = 8'(tx_cnt);
    assign rx_lvl8   = 8'(rx_cnt);
    assign baud_div  = rate_q;

    uart_rx_idle_timer u_tmo (
        .clk(clk), .rst_n(rst_n),
        .mode(ctrl_q.tmo_mode),
        .nonempty(!rx_empty),
        .activity(rx_push || (rd_data && !rx_empty)),
        .char_tick(char_tick),
        .timeout(rx_tmo)
    );

    uart_irq_status u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_lvl8), .rx_level(rx_lvl8),
        .ctrl(ctrl_q), .rx_timeout(rx_tmo),
        .ferr_evt(rx_push && rxb_frame_err),
        .brk_evt(rx_push && rxb_break),
        .ovr_evt(rxb_valid && rx_full),
        .stat_wr(wr_stat), .stat_wdata(bus_wdata[6:0]),
        .stat(stat), .irq(irq)
    );

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (word_idx)
            (ADDR_W-2)'(REG_DATA):
                bus_rdata = rx_empty ? 32'h100
                                     : {21'd0, rx_head[9], rx_head[8], 1'b0, rx_head[7:0]};
            (ADDR_W-2)'(REG_LEVEL): bus_rdata = {16'd0, tx_lvl8, rx_lvl8};
            (ADDR_W-2)'(REG_STAT):  bus_rdata = {26'd0, stat};
            (ADDR_W-2)'(REG_CTRL):  bus_rdata = {14'd0, ctrl_q.tmo_mode, 8'd0,
                                                 ctrl_q.err_en, ctrl_q.rx_en, ctrl_q.tx_en,
                                                 ctrl_q.rx_trig, ctrl_q.tx_trig};
            (ADDR_W-2)'(REG_RATE):  bus_rdata = {24'd0, rate_q};
            default:                bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_host_regs_chk.sv
// Property checker for uart_host_regs, attached with bind.
module uart_host_regs_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        rxb_valid,
    input logic        irq,
    input logic [7:0]  tx_lvl8,
    input logic [7:0]  rx_lvl8,
    input logic [5:0]  stat,
    input logic [2:0]  irq_en,
    input logic [2:0]  rx_trig_code
);
    // Transmit level never exceeds the depth.
    assert_tx_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lvl8 <= 8'(DEPTH));

    // An empty data read carries the empty marker.
    assert_empty_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 5'h00 && rx_lvl8 == 8'd0) |-> bus_rdata[8]);

    // A byte arriving into a full receive FIFO raises overrun.
    assert_overrun_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rxb_valid && rx_lvl8 == 8'(DEPTH)) |=> stat[5]);

    // Level code 0 (one byte) means any waiting byte triggers.
    assert_trig_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_trig_code == 3'd0 && rx_lvl8 != 8'd0) |-> stat[1]);

    // Write of one clears overrun when no new overrun arrives.
    assert_w1c_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 5'h08 && bus_wdata[5] &&
         !(rxb_valid && rx_lvl8 == 8'(DEPTH))) |=> !stat[5]);

    // No enabled cause, no interrupt.
    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 3'b000) |-> !irq);
endmodule

bind uart_host_regs uart_host_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxb_valid(rxb_valid), .irq(irq), .tx_lvl8(tx_lvl8), .rx_lvl8(rx_lvl8),
    .stat(stat), .irq_en({ctrl_q.err_en, ctrl_q.rx_en, ctrl_q.tx_en}),
    .rx_trig_code(ctrl_q.rx_trig)
);

// File: tb/sim_uart_host_regs.sv
// Directed bench for uart_host_regs.
module sim_uart_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txb_valid, txb_ready = 1'b0;
    logic [7:0]  txb_data;
    logic        rxb_valid = 1'b0, rxb_frame_err = 1'b0, rxb_break = 1'b0;
    logic [7:0]  rxb_data = '0;
    logic        char_tick = 1'b0;
    logic [7:0]  baud_div;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txb_valid(txb_valid), .txb_data(txb_data), .txb_ready(txb_ready),
        .rxb_valid(rxb_valid), .rxb_data(rxb_data), .rxb_frame_err(rxb_frame_err),
        .rxb_break(rxb_break), .char_tick(char_tick), .baud_div(baud_div), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rx_byte(input logic [7:0] b, input logic fe, input logic bk);
        @(negedge clk);
        rxb_valid = 1; rxb_data = b; rxb_frame_err = fe; rxb_break = bk;
        @(negedge clk);
        rxb_valid = 0; rxb_frame_err = 0; rxb_break = 0;
    endtask

    task automatic tick();
        @(negedge clk); char_tick = 1;
        @(negedge clk); char_tick = 0;
    endtask

    task automatic open_ready(input int n);
        @(negedge clk); txb_ready = 1;
        repeat (n) @(negedge clk);
        txb_ready = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(5'h04, d); chk("R1 level", d, 32'h0);
        rd(5'h08, d); chk("R1 status", d, 32'h0);
        rd(5'h0C, d); chk("R1 ctrl", d, 32'h0);
        rd(5'h10, d); chk("R1 rate", d, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        chk("R1 txb_valid", {31'd0, txb_valid}, 32'h0);
    endtask

    task automatic t_tx_fill_drain();
        logic [31:0] d;
        for (int i = 0; i < 65; i++) wr(5'h00, 32'(8'(i + 8'h40)));
        rd(5'h04, d); chk("R2 R4 tx level full", d, 32'h4000);
        @(negedge clk); txb_ready = 1;
        for (int i = 0; i < 64; i++) begin
            chk("R2 tx order", {23'd0, txb_valid, txb_data}, {23'd0, 1'b1, 8'(i + 8'h40)});
            @(negedge clk);
        end
        txb_ready = 0;
        chk("R2 drop when full", {31'd0, txb_valid}, 32'h0);
        wr(5'h08, 32'h1);
    endtask

    task automatic t_tx_request();
        logic [31:0] d;
        wr(5'h0C, 32'h2);
        for (int i = 0; i < 12; i++) wr(5'h00, 32'(i));
        wr(5'h08, 32'h1);
        rd(5'h08, d); chk("R10 txreq cleared", d & 32'h1, 32'h0);
        open_ready(3); repeat (3) @(negedge clk);
        rd(5'h08, d); chk("R7 above trigger", d & 32'h1, 32'h0);
        open_ready(1); repeat (3) @(negedge clk);
        rd(5'h04, d); chk("R4 tx level 8", d, 32'h0800);
        rd(5'h08, d); chk("R7 crossing to 8", d & 32'h1, 32'h1);
        open_ready(10);
        wr(5'h08, 32'h1);
        rd(5'h08, d); chk("R10 txreq clear", d & 32'h1, 32'h0);
        wr(5'h08, 32'h40);
        rd(5'h08, d); chk("R7 software set", d, 32'h1);
        wr(5'h08, 32'h1);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_rx_flags();
        logic [31:0] d;
        rx_byte(8'hA5, 0, 0);
        rx_byte(8'h3C, 1, 0);
        rx_byte(8'h81, 0, 1);
        rd(5'h04, d); chk("R4 rx level 3", d, 32'h0003);
        rd(5'h08, d); chk("R9 fe and break", d & 32'h18, 32'h18);
        rd(5'h00, d); chk("R3 plain byte", d, 32'h0A5);
        rd(5'h00, d); chk("R3 frame tag", d, 32'h23C);
        rd(5'h00, d); chk("R3 break tag", d, 32'h481);
        rd(5'h00, d); chk("R3 empty read", d, 32'h100);
        rd(5'h04, d); chk("R3 empty no pop", d, 32'h0);
        wr(5'h08, 32'h0);
        rd(5'h08, d); chk("R10 write zero", d & 32'h18, 32'h18);
        wr(5'h08, 32'h08);
        rd(5'h08, d); chk("R10 clear fe only", d & 32'h18, 32'h10);
        wr(5'h08, 32'h10);
        rd(5'h08, d); chk("R10 clear break", d, 32'h0);
    endtask

    task automatic t_rx_trigger();
        logic [31:0] d;
        wr(5'h0C, 32'h04);
        for (int i = 0; i < 3; i++) rx_byte(8'(i), 0, 0);
        rd(5'h08, d); chk("R6 level 3 of 4", d & 32'h2, 32'h0);
        rx_byte(8'h3, 0, 0);
        rd(5'h08, d); chk("R6 level 4 of 4", d & 32'h2, 32'h2);
        wr(5'h0C, 32'h0C);
        rd(5'h08, d); chk("R6 level 4 of 16", d & 32'h2, 32'h0);
        for (int i = 0; i < 4; i++) rd(5'h00, d);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        for (int i = 0; i < 64; i++) rx_byte(8'(i), 0, 0);
        rd(5'h08, d); chk("R5 no overrun at 64", d & 32'h20, 32'h0);
        rx_byte(8'hEE, 0, 0);
        rd(5'h08, d); chk("R5 overrun set", d & 32'h20, 32'h20);
        rd(5'h04, d); chk("R5 level stays 64", d, 32'h0040);
        for (int i = 0; i < 64; i++) begin
            rd(5'h00, d);
            if (i == 0 || i == 63) chk("R5 stored bytes", d, 32'(i));
        end
        rd(5'h00, d); chk("R5 extra byte discarded", d, 32'h100);
        wr(5'h08, 32'h20);
        rd(5'h08, d); chk("R10 overrun cleared", d, 32'h0);
    endtask

    task automatic t_timeout();
        logic [31:0] d;
        wr(5'h0C, 32'h10000);
        rx_byte(8'h55, 0, 0);
        repeat (3) tick();
        rd(5'h08, d); chk("R8 three ticks", d & 32'h4, 32'h0);
        tick();
        rd(5'h08, d); chk("R8 four ticks", d & 32'h4, 32'h4);
        wr(5'h0C, 32'h0);
        rd(5'h08, d); chk("R8 disabled", d & 32'h4, 32'h0);
        wr(5'h0C, 32'h20000);
        rd(5'h08, d); chk("R8 limit 8 not reached", d & 32'h4, 32'h0);
        rd(5'h00, d);
        wr(5'h0C, 32'h10000);
        rd(5'h08, d); chk("R8 cleared when empty", d & 32'h4, 32'h0);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(5'h08, 32'h40);
        @(negedge clk); chk("R11 masked", {31'd0, irq}, 32'h0);
        wr(5'h0C, 32'h20);
        @(negedge clk); chk("R11 tx enable", {31'd0, irq}, 32'h1);
        wr(5'h08, 32'h1);
        @(negedge clk); chk("R11 tx cleared", {31'd0, irq}, 32'h0);
        rx_byte(8'h11, 1, 0);
        @(negedge clk); chk("R11 err not enabled", {31'd0, irq}, 32'h0);
        wr(5'h0C, 32'h80);
        @(negedge clk); chk("R11 err enable", {31'd0, irq}, 32'h1);
        wr(5'h0C, 32'h40);
        @(negedge clk); chk("R11 rx enable", {31'd0, irq}, 32'h1);
        rd(5'h00, d);
        @(negedge clk); chk("R11 rx drained", {31'd0, irq}, 32'h0);
        wr(5'h08, 32'h08);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_ctrl_rate();
        logic [31:0] d;
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, d); chk("R12 ctrl readback", d, 32'h0003_00FF);
        wr(5'h0C, 32'h0);
        wr(5'h10, 32'h0000_1234);
        rd(5'h10, d); chk("R12 rate readback", d, 32'h34);
        chk("R12 baud_div", {24'd0, baud_div}, 32'h34);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_tx_fill_drain();
        t_tx_request();
        t_rx_flags();
        t_rx_trigger();
        t_overrun();
        t_timeout();
        t_irq();
        t_ctrl_rate();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule